// File: doc/BRIEF.md
# Processor Fault Entry Controller

This block records a fault request into the control-unit state of a processor and steers the processor into its fault cycle. A requester presents a 5-bit fault number, a flag marking that number as outside the legal range, a subfault word and the kind of cycle the processor is in. It qualifies these with a single-cycle strobe. On the following clock edge every piece of fault state is updated together, and a one-cycle acknowledge marks the entry into the fault cycle.

The state held here is as follows. There is the recorded fault number and subfault word, and a 12-bit cycle-bits register whose low three bits count faults. There is the fault-address field, a flag telling that the fault hit during an instruction fetch, and a connect channel field. There are sixteen access-violation status flags and an instruction counter. A fault raised while the processor is already running its fault sequence is turned into a trouble fault. Two such nested faults in a row, with no interrupt pending to break the loop, raise a sticky cascade-halt output.

Cycle type codes on `cycleType`: 0 = fetch, 1 = execute, 2 = fault-execute, 3 = any other cycle. Fault numbers with their own handling: 8 = connect, 20 = access violation, 31 = trouble.

Top module: `fault_entry_ctrl`

## Requirements
- R1: A strobed fault with `outOfRange` high is recorded as fault number 31, whatever `faultNum` carries.
- R2: Every strobed fault adds one, modulo 8, to bits 2:0 of `cycleBits`. Bits 11:3 keep the value given by parameter `CB_UPPER_INIT` from reset on.
- R3: `faultAddr` takes the recorded 5-bit fault number. `fetchFault` is set only when the fault arrives with cycle code 0 (fetch), and is cleared by any other strobed fault.
- R4: When the requested fault is number 20 (access violation), `acvFlags[i]` takes subfault bit i for i = 0..15. For any other requested fault, all sixteen flags are cleared.
- R5: When the requested fault is number 8 (connect), `connChan` takes subfault bits 2:0. For any other requested fault, it takes 0.
- R6: A fault arriving with cycle code 2 (fault-execute) records fault number 31 in `faultNumReg` and `faultAddr`, and 0 in `subFaultReg`. R4 and R5 still follow the requested number. Outside cycle code 2, `subFaultReg` takes the subfault word.
- R7: The first cycle-code-2 fault sets `troubleCycle`. A cycle-code-2 fault with `troubleCycle` already set raises `cascadeHalt` if `irqPending` is low, and leaves `troubleCycle` set. `cascadeHalt` then stays high until reset. With `irqPending` high no halt is raised.
- R8: A strobed fault in any cycle other than code 2 clears `troubleCycle`.
- R9: A fault arriving with cycle code 1 (execute) adds one to `instrCount`, modulo 2^INSTR_W. Other cycle codes leave it unchanged.
- R10: `faultAck` is high for exactly the one cycle after each strobe, and low otherwise.
- R11: Synchronous active-high reset clears all outputs. The exception is `cycleBits[11:3]`, which takes `CB_UPPER_INIT`.
- R12: With `faultReq` low, no output other than `faultAck` changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| faultReq | input | 1 | Single-cycle fault request strobe |
| faultNum | input | 5 | Requested fault number |
| outOfRange | input | 1 | Requested number is illegal; record trouble |
| subFault | input | SUB_W (16) | Subfault word |
| cycleType | input | 2 | Current cycle: 0 fetch, 1 execute, 2 fault-execute, 3 other |
| irqPending | input | 1 | An interrupt is pending |
| faultAck | output | 1 | One-cycle acknowledge; fault cycle entered |
| faultNumReg | output | 5 | Recorded fault number |
| subFaultReg | output | SUB_W (16) | Recorded subfault word |
| cycleBits | output | CB_W (12) | Cycle-bits register with fault counter in low bits |
| faultAddr | output | 5 | Fault-address field |
| fetchFault | output | 1 | Fault arrived during fetch |
| connChan | output | 3 | Connect channel field |
| acvFlags | output | SUB_W (16) | Access-violation status flags |
| troubleCycle | output | 1 | A nested fault has been escalated |
| cascadeHalt | output | 1 | Sticky halt after a fault cascade |
| instrCount | output | INSTR_W (8) | Instruction counter |

## Verification
The bench builds the block with `INSTR_W` = 4, so the instruction counter wraps after sixteen execute-cycle faults. Over thirty faults are sent, which also wraps the 3-bit fault counter several times within a short run. It sets `CB_UPPER_INIT` to a nonzero pattern (0x15A), so a stray write to the kept upper cycle bits shows up as a changed value rather than staying at zero. The sixteen-flag width stays at its default so every flag can be driven by distinct subfault patterns.

// File: rtl/fault_entry_pkg.sv
package fault_entry_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH   = 2'd0,
    CYC_EXEC    = 2'd1,
    CYC_FLTEXEC = 2'd2,
    CYC_OTHER   = 2'd3
  } cycle_e;

  localparam int NUM_W = 5;

  localparam logic [NUM_W-1:0] FN_CONNECT = 5'd8;
  localparam logic [NUM_W-1:0] FN_ACCESS  = 5'd20;
  localparam logic [NUM_W-1:0] FN_TROUBLE = 5'd31;

  // strobes from control to datapath, valid only in the request cycle
  typedef struct packed {
    logic capture;
    logic escalate;
    logic acvLoad;
    logic conLoad;
    logic fetchHit;
    logic countInstr;
  } strobe_t;

endpackage

// File: rtl/fault_entry_control.sv
module fault_entry_control
  import fault_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             faultReq,
  input  logic [NUM_W-1:0] faultNum,
  input  logic             outOfRange,
  input  logic [1:0]       cycleType,
  input  logic             irqPending,
  output strobe_t          strb,
  output logic [NUM_W-1:0] effNum,
  output logic             troubleCycle,
  output logic             cascadeHalt,
  output logic             faultAck
);

  cycle_e cyc;

  always_comb begin
    cyc    = cycle_e'(cycleType);
    effNum = outOfRange ? FN_TROUBLE : faultNum;

    strb.capture    = faultReq;
    strb.escalate   = faultReq && (cyc == CYC_FLTEXEC);
    strb.acvLoad    = faultReq && (effNum == FN_ACCESS);
    strb.conLoad    = faultReq && (effNum == FN_CONNECT);
    strb.fetchHit   = faultReq && (cyc == CYC_FETCH);
    strb.countInstr = faultReq && (cyc == CYC_EXEC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      troubleCycle <= 1'b0;
      cascadeHalt  <= 1'b0;
      faultAck     <= 1'b0;
    end else begin
      faultAck <= faultReq;
      if (faultReq) begin
        if (strb.escalate) begin
          if (troubleCycle) begin
            if (!irqPending) cascadeHalt <= 1'b1;
          end else begin
            troubleCycle <= 1'b1;
          end
        end else begin
          troubleCycle <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/fault_entry_datapath.sv
module fault_entry_datapath
  import fault_entry_pkg::*;
#(
  parameter int SUB_W   = 16,
  parameter int CB_W    = 12,
  parameter int FCT_W   = 3,
  parameter int INSTR_W = 8,
  parameter logic [CB_W-FCT_W-1:0] CB_UPPER_INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strb,
  input  logic [NUM_W-1:0]   effNum,
  input  logic [SUB_W-1:0]   subFault,
  output logic [NUM_W-1:0]   faultNumReg,
  output logic [SUB_W-1:0]   subFaultReg,
  output logic [CB_W-1:0]    cycleBits,
  output logic [NUM_W-1:0]   faultAddr,
  output logic               fetchFault,
  output logic [2:0]         connChan,
  output logic [SUB_W-1:0]   acvFlags,
  output logic [INSTR_W-1:0] instrCount
);

  localparam int UPPER_W = CB_W - FCT_W;

  logic [NUM_W-1:0] recNum;
  assign recNum = strb.escalate ? FN_TROUBLE : effNum;

  always_ff @(posedge clk) begin
    if (rst) begin
      faultNumReg <= '0;
      subFaultReg <= '0;
      faultAddr   <= '0;
      fetchFault  <= 1'b0;
      connChan    <= '0;
      instrCount  <= '0;
      cycleBits   <= {CB_UPPER_INIT, {FCT_W{1'b0}}};
    end else if (strb.capture) begin
      faultNumReg <= recNum;
      faultAddr   <= recNum;
      subFaultReg <= strb.escalate ? '0 : subFault;
      fetchFault  <= strb.fetchHit;
      connChan    <= strb.conLoad ? subFault[2:0] : 3'd0;
      cycleBits   <= {cycleBits[CB_W-1:FCT_W],
                      cycleBits[FCT_W-1:0] + FCT_W'(1)};
      if (strb.countInstr) instrCount <= instrCount + INSTR_W'(1);
    end
  end

  // one status flag per subfault bit; each is cleared unless this is an
  // access-violation fault carrying that bit
  for (genvar i = 0; i < SUB_W; i++) begin : g_acv
    always_ff @(posedge clk) begin
      if (rst)               acvFlags[i] <= 1'b0;
      else if (strb.capture) acvFlags[i] <= strb.acvLoad & subFault[i];
    end
  end

  logic [UPPER_W-1:0] upperUnused;
  assign upperUnused = cycleBits[CB_W-1:FCT_W];

endmodule

// File: rtl/fault_entry_ctrl.sv
module fault_entry_ctrl
  import fault_entry_pkg::*;
#(
  parameter int SUB_W   = 16,
  parameter int CB_W    = 12,
  parameter int FCT_W   = 3,
  parameter int INSTR_W = 8,
  parameter logic [CB_W-FCT_W-1:0] CB_UPPER_INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               faultReq,
  input  logic [4:0]         faultNum,
  input  logic               outOfRange,
  input  logic [SUB_W-1:0]   subFault,
  input  logic [1:0]         cycleType,
  input  logic               irqPending,
  output logic               faultAck,
  output logic [4:0]         faultNumReg,
  output logic [SUB_W-1:0]   subFaultReg,
  output logic [CB_W-1:0]    cycleBits,
  output logic [4:0]         faultAddr,
  output logic               fetchFault,
  output logic [2:0]         connChan,
  output logic [SUB_W-1:0]   acvFlags,
  output logic               troubleCycle,
  output logic               cascadeHalt,
  output logic [INSTR_W-1:0] instrCount
);

  strobe_t          strb;
  logic [NUM_W-1:0] effNum;

  fault_entry_control u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .faultReq     (faultReq),
    .faultNum     (faultNum),
    .outOfRange   (outOfRange),
    .cycleType    (cycleType),
    .irqPending   (irqPending),
    .strb         (strb),
    .effNum       (effNum),
    .troubleCycle (troubleCycle),
    .cascadeHalt  (cascadeHalt),
    .faultAck     (faultAck)
  );

  fault_entry_datapath #(
    .SUB_W         (SUB_W),
    .CB_W          (CB_W),
    .FCT_W         (FCT_W),
    .INSTR_W       (INSTR_W),
    .CB_UPPER_INIT (CB_UPPER_INIT)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .effNum      (effNum),
    .subFault    (subFault),
    .faultNumReg (faultNumReg),
    .subFaultReg (subFaultReg),
    .cycleBits   (cycleBits),
    .faultAddr   (faultAddr),
    .fetchFault  (fetchFault),
    .connChan    (connChan),
    .acvFlags    (acvFlags),
    .instrCount  (instrCount)
  );

endmodule

// File: rtl/fault_entry_ctrl_chk.sv
module fault_entry_ctrl_chk #(
  parameter int SUB_W   = 16,
  parameter int CB_W    = 12,
  parameter int FCT_W   = 3,
  parameter int INSTR_W = 8,
  parameter logic [CB_W-FCT_W-1:0] CB_UPPER_INIT = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               faultReq,
  input logic [4:0]         faultNum,
  input logic               outOfRange,
  input logic [SUB_W-1:0]   subFault,
  input logic [1:0]         cycleType,
  input logic               irqPending,
  input logic               faultAck,
  input logic [4:0]         faultNumReg,
  input logic [SUB_W-1:0]   subFaultReg,
  input logic [CB_W-1:0]    cycleBits,
  input logic [4:0]         faultAddr,
  input logic               fetchFault,
  input logic [2:0]         connChan,
  input logic [SUB_W-1:0]   acvFlags,
  input logic               troubleCycle,
  input logic               cascadeHalt,
  input logic [INSTR_W-1:0] instrCount
);

  a_r1_out_of_range: assert property (@(posedge clk) disable iff (rst)
    faultReq && outOfRange |=> faultNumReg == 5'd31);

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    faultReq |=> cycleBits[FCT_W-1:0] == FCT_W'($past(cycleBits[FCT_W-1:0]) + 1'b1));

  a_r2_upper_kept: assert property (@(posedge clk) disable iff (rst)
    cycleBits[CB_W-1:FCT_W] == CB_UPPER_INIT);

  a_r3_addr_matches: assert property (@(posedge clk) disable iff (rst)
    faultAck |-> faultAddr == faultNumReg);

  a_r4_flags_only_acv: assert property (@(posedge clk) disable iff (rst)
    faultReq && !outOfRange && faultNum != 5'd20 |=> acvFlags == '0);

  a_r6_escalate: assert property (@(posedge clk) disable iff (rst)
    faultReq && cycleType == 2'd2 |=> faultNumReg == 5'd31 && subFaultReg == '0);

  a_r7_halt_needs_trouble: assert property (@(posedge clk) disable iff (rst)
    $rose(cascadeHalt) |-> $past(troubleCycle) && !$past(irqPending));

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    cascadeHalt |=> cascadeHalt);

  a_r8_clear_trouble: assert property (@(posedge clk) disable iff (rst)
    faultReq && cycleType != 2'd2 |=> !troubleCycle);

  a_r10_ack: assert property (@(posedge clk) disable iff (rst)
    faultReq |=> faultAck);

  a_r10_ack_idle: assert property (@(posedge clk) disable iff (rst)
    !faultReq |=> !faultAck);

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !faultReq |=> $stable(faultNumReg) && $stable(subFaultReg) && $stable(cycleBits)
                  && $stable(acvFlags) && $stable(instrCount) && $stable(troubleCycle));

endmodule

bind fault_entry_ctrl fault_entry_ctrl_chk #(
  .SUB_W         (SUB_W),
  .CB_W          (CB_W),
  .FCT_W         (FCT_W),
  .INSTR_W       (INSTR_W),
  .CB_UPPER_INIT (CB_UPPER_INIT)
) u_chk (.*);

// File: tb/fault_entry_ctrl_test.sv
module fault_entry_ctrl_test;

  localparam int SUB_W   = 16;
  localparam int CB_W    = 12;
  localparam int FCT_W   = 3;
  localparam int INSTR_W = 4;
  localparam logic [CB_W-FCT_W-1:0] UPPER = 9'h15A;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               faultReq = 1'b0;
  logic [4:0]         faultNum = '0;
  logic               outOfRange = 1'b0;
  logic [SUB_W-1:0]   subFault = '0;
  logic [1:0]         cycleType = '0;
  logic               irqPending = 1'b0;
  logic               faultAck;
  logic [4:0]         faultNumReg;
  logic [SUB_W-1:0]   subFaultReg;
  logic [CB_W-1:0]    cycleBits;
  logic [4:0]         faultAddr;
  logic               fetchFault;
  logic [2:0]         connChan;
  logic [SUB_W-1:0]   acvFlags;
  logic               troubleCycle;
  logic               cascadeHalt;
  logic [INSTR_W-1:0] instrCount;

  always #2 clk = ~clk;

  fault_entry_ctrl #(
    .SUB_W(SUB_W), .CB_W(CB_W), .FCT_W(FCT_W), .INSTR_W(INSTR_W), .CB_UPPER_INIT(UPPER)
  ) uut (.*);

  typedef struct {
    logic [4:0]         num;
    logic [SUB_W-1:0]   sub;
    logic [CB_W-1:0]    cb;
    logic [4:0]         addr;
    logic               fetch;
    logic [2:0]         conn;
    logic [SUB_W-1:0]   acv;
    logic               trouble;
    logic               halt;
    logic [INSTR_W-1:0] instr;
  } exp_t;

  exp_t sbQ[$];
  exp_t lastExp;
  exp_t resetExp;

  int checks = 0;
  int fails = 0;
  logic armed = 1'b0;
  logic done = 1'b0;

  // reference state
  logic [2:0]         mFct;
  logic               mTr;
  logic               mHalt;
  logic [INSTR_W-1:0] mInstr;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(exp_t e, string ctx);
    check({"R1/R6 faultNumReg ", ctx}, 32'(faultNumReg), 32'(e.num));
    check({"R6 subFaultReg ", ctx}, 32'(subFaultReg), 32'(e.sub));
    check({"R2 cycleBits ", ctx}, 32'(cycleBits), 32'(e.cb));
    check({"R3 faultAddr ", ctx}, 32'(faultAddr), 32'(e.addr));
    check({"R3 fetchFault ", ctx}, 32'(fetchFault), 32'(e.fetch));
    check({"R5 connChan ", ctx}, 32'(connChan), 32'(e.conn));
    check({"R4 acvFlags ", ctx}, 32'(acvFlags), 32'(e.acv));
    check({"R7/R8 troubleCycle ", ctx}, 32'(troubleCycle), 32'(e.trouble));
    check({"R7 cascadeHalt ", ctx}, 32'(cascadeHalt), 32'(e.halt));
    check({"R9 instrCount ", ctx}, 32'(instrCount), 32'(e.instr));
  endtask

  function automatic exp_t resetValue();
    exp_t e;
    e.num = '0; e.sub = '0; e.cb = {UPPER, 3'd0}; e.addr = '0; e.fetch = 1'b0;
    e.conn = '0; e.acv = '0; e.trouble = 1'b0; e.halt = 1'b0; e.instr = '0;
    return e;
  endfunction

  // scoreboard monitor: compare on acknowledge, otherwise demand no change
  always @(negedge clk) begin
    if (armed) begin
      if (faultAck) begin
        if (sbQ.size() == 0) begin
          check("R10 unexpected faultAck", 32'(faultAck), 32'd0);
        end else begin
          lastExp = sbQ.pop_front();
          check("R10 faultAck high after strobe", 32'(faultAck), 32'd1);
          compareAll(lastExp, "on ack");
        end
      end else begin
        compareAll(lastExp, "R12 idle hold");
      end
    end
  end

  task automatic fire(logic [4:0] n, logic oor, logic [SUB_W-1:0] s, logic [1:0] cyc, logic irq);
    exp_t e;
    logic [4:0] eff;
    logic fx;
    eff = oor ? 5'd31 : n;
    fx  = (cyc == 2'd2);
    e.acv   = (eff == 5'd20) ? s : '0;
    e.conn  = (eff == 5'd8) ? s[2:0] : 3'd0;
    e.num   = fx ? 5'd31 : eff;
    e.addr  = e.num;
    e.sub   = fx ? '0 : s;
    mFct    = mFct + 3'd1;
    e.cb    = {UPPER, mFct};
    e.fetch = (cyc == 2'd0);
    if (fx) begin
      if (mTr) begin
        if (!irq) mHalt = 1'b1;
      end else mTr = 1'b1;
    end else mTr = 1'b0;
    if (cyc == 2'd1) mInstr = mInstr + 1'b1;
    e.trouble = mTr;
    e.halt    = mHalt;
    e.instr   = mInstr;
    @(negedge clk);
    faultNum = n; outOfRange = oor; subFault = s; cycleType = cyc; irqPending = irq;
    faultReq = 1'b1;
    sbQ.push_back(e);
    @(negedge clk);
    faultReq = 1'b0;
  endtask

  // idle cycles with busy inputs and no strobe (R12)
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      faultNum = 5'(i * 7 + 20); outOfRange = i[0]; subFault = 16'(i * 16'h3B1D);
      cycleType = 2'(i); irqPending = i[1];
    end
  endtask

  task automatic doReset();
    armed = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mFct = '0; mTr = 1'b0; mHalt = 1'b0; mInstr = '0;
    @(negedge clk);
    // R11 reset state
    compareAll(resetExp, "R11 after reset");
    check("R11 faultAck after reset", 32'(faultAck), 32'd0);
    lastExp = resetExp;
    armed = 1'b1;
  endtask

  initial begin
    resetExp = resetValue();
    doReset();

    fire(5'd5, 1'b0, 16'h1234, 2'd0, 1'b0);      // R3 fetch
    idle(3);
    fire(5'd20, 1'b0, 16'hA5C3, 2'd1, 1'b0);     // R4 access violation, R9
    fire(5'd8, 1'b0, 16'h000E, 2'd3, 1'b0);      // R5 connect channel 6
    fire(5'd7, 1'b1, 16'h00FF, 2'd3, 1'b0);      // R1 out of range
    fire(5'd20, 1'b0, 16'hFFFF, 2'd0, 1'b0);     // R4 all flags
    fire(5'd13, 1'b0, 16'hFFFF, 2'd1, 1'b0);     // R4 cleared by other fault
    idle(4);
    fire(5'd20, 1'b0, 16'h0181, 2'd2, 1'b0);     // R6 escalate, R7 first sets flag
    fire(5'd2, 1'b0, 16'h0003, 2'd3, 1'b0);      // R8 clears flag
    fire(5'd8, 1'b0, 16'h0005, 2'd2, 1'b0);      // R6/R5 escalate keeps channel
    fire(5'd9, 1'b0, 16'h0001, 2'd2, 1'b1);      // R7 irq pending: no halt
    idle(2);
    for (int i = 0; i < 20; i++)                  // R9 wrap, R2 wrap
      fire(5'(i), i[2], 16'(i * 16'h0913), 2'd1, 1'b0);
    fire(5'd4, 1'b0, 16'h0000, 2'd2, 1'b0);      // R7 first escalation again
    fire(5'd4, 1'b0, 16'h0000, 2'd2, 1'b0);      // R7 cascade halt
    idle(3);
    fire(5'd11, 1'b0, 16'h0042, 2'd0, 1'b0);     // R7 halt stays, R8 clears flag
    idle(2);
    doReset();                                   // R11 halt cleared by reset
    fire(5'd31, 1'b0, 16'h8001, 2'd1, 1'b0);
    idle(3);
    check("R10 queue drained", 32'(sbQ.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule